// File: doc/BRIEF.md
# Non-Speculative Instruction Hold Buffer

This block sits beside an issue queue and parks instructions that may not issue speculatively: stores and serializing operations. Each parked instruction occupies one hold slot, tagged with its sequence number, its class code and a memory flag. A parked instruction never becomes issuable through operand readiness or arrival order. It leaves only when the commit side reports its sequence number as the one now at the head of the reorder buffer.

When such a report matches exactly one parked entry, the block frees that slot. On the next cycle it presents the entry on a release output, marked issuable, so that the ready-routing logic can pick it up. A report that matches no entry, or more than one entry, raises an error pulse instead. A squash port removes every parked entry younger than a given sequence number. Sequence numbers compare as unsigned values, and a larger value is younger.

The block reports its number of free slots and a full flag. The full flag back-pressures the insert port.

Top module: `nsb_hold_buf`

## Requirements
- R1: After reset no slot is occupied: `free_cnt` equals SLOTS, `full` is 0, and `rel_vld_o` and `err_o` are 0.
- R2: An insert (`ins_valid`=1 while `full`=0) takes one slot, so `free_cnt` drops by one at the next edge. A parked entry is never presented on the release output without a matching release request.
- R3: `full` is 1 exactly when `free_cnt` is 0. An insert while `full` is 1 is ignored and leaves `free_cnt` unchanged.
- R4: A release request (`rel_valid`) whose `rel_seq` equals the sequence number of exactly one parked entry frees that slot. On the following cycle the block drives `rel_vld_o`=1 together with that entry's sequence number, class and memory flag.
- R5: A release request that matches no parked entry drives `err_o`=1 for one cycle on the following cycle. It gives no release output and changes no slot.
- R6: A release request that matches two or more parked entries drives `err_o`=1 on the following cycle. It gives no release output, and all matching entries stay parked.
- R7: A squash (`sq_valid`) removes every parked entry whose sequence number is greater than `sq_seq` (unsigned) and keeps every entry whose sequence number is less than or equal to it.
- R8: When a squash removes the entry that a release request matches in the same cycle, the squash wins: no release output and no error follow.
- R9: An entry inserted in a cycle is not affected by a squash in that same cycle. It cannot be matched by a release request in that same cycle, and such a request counts as a miss (R5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert request |
| ins_seq | input | SEQ_W | Sequence number of the inserted instruction |
| ins_cls | input | CLS_W | Class code of the inserted instruction |
| ins_mem | input | 1 | Inserted instruction accesses memory |
| rel_valid | input | 1 | Commit reports a sequence number at the reorder buffer head |
| rel_seq | input | SEQ_W | Reported head sequence number |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Entries with a greater sequence number are removed |
| full | output | 1 | All slots occupied; inserts are ignored |
| free_cnt | output | $clog2(SLOTS+1) | Number of unoccupied slots |
| rel_vld_o | output | 1 | Released entry presented as issuable |
| rel_seq_o | output | SEQ_W | Sequence number of the released entry |
| rel_cls_o | output | CLS_W | Class code of the released entry |
| rel_mem_o | output | 1 | Memory flag of the released entry |
| err_o | output | 1 | Previous release request matched zero or several entries |

## Verification
The release output and the error pulse are registered. Both are due exactly one cycle after the edge that samples the release request. `free_cnt` and `full` reflect an insert, release or squash from the edge that samples it. The bench drives each cycle's stimulus on the falling edge and advances its queue model at that moment. At the next falling edge it compares the model against every output, so each result is checked in the one cycle it is due.

// File: rtl/nsb_pkg.sv
package nsb_pkg;

    // Classification of a release request against the parked entries
    typedef enum logic [1:0] {
        REL_IDLE = 2'd0,
        REL_HIT  = 2'd1,
        REL_BAD  = 2'd2
    } rel_kind_e;

endpackage

// File: rtl/nsb_cmp.sv
// Per-slot comparison of stored sequence numbers against one key.
// GREATER=0: equality vector; GREATER=1: stored value above key.
module nsb_cmp #(
    parameter int SLOTS   = 8,
    parameter int SEQ_W   = 8,
    parameter bit GREATER = 1'b0
) (
    input  logic [SLOTS-1:0][SEQ_W-1:0] seq_i,
    input  logic [SEQ_W-1:0]            key_i,
    output logic [SLOTS-1:0]            hit_o
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (GREATER) begin : g_gt
            assign hit_o[g] = seq_i[g] > key_i;
        end else begin : g_eq
            assign hit_o[g] = seq_i[g] == key_i;
        end
    end
endmodule

// File: rtl/nsb_first.sv
// Index of the lowest set bit of a request vector.
module nsb_first #(
    parameter int N     = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             found_o
);
    always_comb begin
        idx_o   = '0;
        found_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o   = IDX_W'(i);
                found_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/nsb_hold_buf.sv
module nsb_hold_buf #(
    parameter int SLOTS = 8,
    parameter int SEQ_W = 8,
    parameter int CLS_W = 3,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic [CLS_W-1:0] ins_cls,
    input  logic             ins_mem,
    input  logic             rel_valid,
    input  logic [SEQ_W-1:0] rel_seq,
    input  logic             sq_valid,
    input  logic [SEQ_W-1:0] sq_seq,
    output logic             full,
    output logic [CNT_W-1:0] free_cnt,
    output logic             rel_vld_o,
    output logic [SEQ_W-1:0] rel_seq_o,
    output logic [CLS_W-1:0] rel_cls_o,
    output logic             rel_mem_o,
    output logic             err_o
);
    import nsb_pkg::*;

    typedef struct packed {
        logic [SLOTS-1:0]            vld;
        logic [SLOTS-1:0][SEQ_W-1:0] seq;
        logic [SLOTS-1:0][CLS_W-1:0] cls;
        logic [SLOTS-1:0]            mem;
        logic                        out_vld;
        logic [SEQ_W-1:0]            out_seq;
        logic [CLS_W-1:0]            out_cls;
        logic                        out_mem;
        logic                        out_err;
    } state_t;

    state_t s_d, s_q;

    logic [SLOTS-1:0] eq_vec, gt_vec, hit_vec, kill_vec;
    logic [IDX_W-1:0] hit_idx, free_idx;
    logic             hit_any, free_any;
    logic [CNT_W-1:0] hit_cnt, occ_cnt;
    rel_kind_e        rel_kind;
    logic             rel_go, ins_go;

    nsb_cmp #(.SLOTS(SLOTS), .SEQ_W(SEQ_W), .GREATER(1'b0)) u_rel_cmp (
        .seq_i(s_q.seq), .key_i(rel_seq), .hit_o(eq_vec)
    );

    nsb_cmp #(.SLOTS(SLOTS), .SEQ_W(SEQ_W), .GREATER(1'b1)) u_sq_cmp (
        .seq_i(s_q.seq), .key_i(sq_seq), .hit_o(gt_vec)
    );

    assign hit_vec  = eq_vec & s_q.vld;
    assign kill_vec = sq_valid ? (gt_vec & s_q.vld) : '0;

    nsb_first #(.N(SLOTS)) u_hit_pick (
        .req_i(hit_vec), .idx_o(hit_idx), .found_o(hit_any)
    );

    nsb_first #(.N(SLOTS)) u_free_pick (
        .req_i(~s_q.vld), .idx_o(free_idx), .found_o(free_any)
    );

    // Occupancy and match counts
    always_comb begin
        hit_cnt = '0;
        occ_cnt = '0;
        for (int i = 0; i < SLOTS; i++) begin
            hit_cnt = hit_cnt + CNT_W'(hit_vec[i]);
            occ_cnt = occ_cnt + CNT_W'(s_q.vld[i]);
        end
    end

    assign full     = &s_q.vld;
    assign free_cnt = CNT_W'(SLOTS) - occ_cnt;

    always_comb begin
        if (!rel_valid)                         rel_kind = REL_IDLE;
        else if (hit_any && hit_cnt == CNT_W'(1)) rel_kind = REL_HIT;
        else                                    rel_kind = REL_BAD;
    end

    // Squash beats release of the same entry
    assign rel_go = (rel_kind == REL_HIT) && !kill_vec[hit_idx];
    assign ins_go = ins_valid && free_any;

    always_comb begin
        s_d         = s_q;
        s_d.out_vld = rel_go;
        s_d.out_err = (rel_kind == REL_BAD);
        s_d.out_seq = '0;
        s_d.out_cls = '0;
        s_d.out_mem = 1'b0;
        s_d.vld     = s_q.vld & ~kill_vec;
        if (rel_go) begin
            s_d.out_seq      = s_q.seq[hit_idx];
            s_d.out_cls      = s_q.cls[hit_idx];
            s_d.out_mem      = s_q.mem[hit_idx];
            s_d.vld[hit_idx] = 1'b0;
        end
        if (ins_go) begin
            s_d.vld[free_idx] = 1'b1;
            s_d.seq[free_idx] = ins_seq;
            s_d.cls[free_idx] = ins_cls;
            s_d.mem[free_idx] = ins_mem;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rel_vld_o = s_q.out_vld;
    assign rel_seq_o = s_q.out_seq;
    assign rel_cls_o = s_q.out_cls;
    assign rel_mem_o = s_q.out_mem;
    assign err_o     = s_q.out_err;

    // ---------------- assertions ----------------
    // R2: a lone accepted insert consumes exactly one slot
    a_r2_insert_takes_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !full && !rel_valid && !sq_valid)
        |=> free_cnt == $past(free_cnt) - CNT_W'(1));

    // R3: a rejected insert alone leaves the count unchanged
    a_r3_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && full && !rel_valid && !sq_valid) |=> full);

    // R4: a release output always answers a request for that same number
    a_r4_out_has_request: assert property (@(posedge clk) disable iff (!rst_n)
        rel_vld_o |-> ($past(rel_valid) && $past(rel_seq) == rel_seq_o));

    // R5 and R6: an error pulse needs a request, and excludes a release
    a_r5_err_has_request: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($past(rel_valid) && !rel_vld_o));

    // R8: a release for a number the same-cycle squash covers yields nothing
    a_r8_squash_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && rel_valid && rel_seq > sq_seq) |=> !rel_vld_o);

    // R3: full and free count agree
    always_comb begin
        if (rst_n) begin
            a_r3_full_matches_count: assert (full == (free_cnt == '0));
        end
    end
endmodule

// File: tb/nsb_hold_buf_tb.sv
module nsb_hold_buf_tb;
    localparam int SLOTS = 8;
    localparam int SEQ_W = 8;
    localparam int CLS_W = 3;
    localparam int CNT_W = $clog2(SLOTS + 1);
    localparam int CLK_P = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ins_valid = 1'b0, ins_mem = 1'b0;
    logic [SEQ_W-1:0] ins_seq = '0;
    logic [CLS_W-1:0] ins_cls = '0;
    logic             rel_valid = 1'b0, sq_valid = 1'b0;
    logic [SEQ_W-1:0] rel_seq = '0, sq_seq = '0;
    logic             full, rel_vld_o, rel_mem_o, err_o;
    logic [CNT_W-1:0] free_cnt;
    logic [SEQ_W-1:0] rel_seq_o;
    logic [CLS_W-1:0] rel_cls_o;

    nsb_hold_buf #(.SLOTS(SLOTS), .SEQ_W(SEQ_W), .CLS_W(CLS_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_seq(ins_seq), .ins_cls(ins_cls), .ins_mem(ins_mem),
        .rel_valid(rel_valid), .rel_seq(rel_seq),
        .sq_valid(sq_valid), .sq_seq(sq_seq),
        .full(full), .free_cnt(free_cnt),
        .rel_vld_o(rel_vld_o), .rel_seq_o(rel_seq_o), .rel_cls_o(rel_cls_o),
        .rel_mem_o(rel_mem_o), .err_o(err_o)
    );

    always #(CLK_P / 2) clk = ~clk;

    typedef struct {
        logic [SEQ_W-1:0] seq;
        logic [CLS_W-1:0] cls;
        logic             mem;
    } ent_t;

    ent_t mq[$];
    logic e_vld, e_mem, e_err;
    logic [SEQ_W-1:0] e_seq;
    logic [CLS_W-1:0] e_cls;
    int   checks = 0, errs = 0;
    bit   done = 0;
    string tag = "R1";

    task automatic chk(string what, int act, int expv);
        checks++;
        if (act != expv) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic compare();
        chk("free_cnt", int'(free_cnt), SLOTS - mq.size());
        chk("full", int'(full), int'(mq.size() == SLOTS));
        chk("rel_vld_o", int'(rel_vld_o), int'(e_vld));
        chk("err_o", int'(err_o), int'(e_err));
        if (e_vld) begin
            chk("rel_seq_o", int'(rel_seq_o), int'(e_seq));
            chk("rel_cls_o", int'(rel_cls_o), int'(e_cls));
            chk("rel_mem_o", int'(rel_mem_o), int'(e_mem));
        end
    endtask

    // Drive one cycle at the falling edge, advance model, compare next falling edge
    task automatic cyc(bit iv, int is, int ic, bit im, bit rv, int rs, bit sv, int ss);
        int   nh, hi, pre;
        ent_t keep[$];
        ent_t ne;
        ins_valid = iv; ins_seq = SEQ_W'(is); ins_cls = CLS_W'(ic); ins_mem = im;
        rel_valid = rv; rel_seq = SEQ_W'(rs);
        sq_valid = sv;  sq_seq = SEQ_W'(ss);
        nh = 0; hi = -1; pre = mq.size();
        foreach (mq[i]) if (mq[i].seq == SEQ_W'(rs)) begin nh++; hi = i; end
        e_vld = 1'b0; e_err = 1'b0;
        if (rv) begin
            if (nh != 1) e_err = 1'b1;
            else begin
                if (!(sv && mq[hi].seq > SEQ_W'(ss))) begin
                    e_vld = 1'b1; e_seq = mq[hi].seq; e_cls = mq[hi].cls; e_mem = mq[hi].mem;
                end
                mq.delete(hi);
            end
        end
        if (sv) begin
            foreach (mq[i]) if (mq[i].seq <= SEQ_W'(ss)) keep.push_back(mq[i]);
            mq = keep;
        end
        if (iv && pre < SLOTS) begin
            ne.seq = SEQ_W'(is); ne.cls = CLS_W'(ic); ne.mem = im;
            mq.push_back(ne);
        end
        @(negedge clk);
        compare();
    endtask

    task automatic ins(int s, int c, bit m);
        cyc(1, s, c, m, 0, 0, 0, 0);
    endtask
    task automatic rel(int s);
        cyc(0, 0, 0, 0, 1, s, 0, 0);
    endtask
    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        e_vld = 0; e_err = 0; e_seq = '0; e_cls = '0; e_mem = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1 reset";
        compare();

        tag = "R2 insert";
        ins(10, 1, 1'b1); ins(11, 2, 1'b0); ins(12, 5, 1'b1);
        idle(); idle();                       // parked entries stay silent

        tag = "R4 release";
        rel(11); idle(); rel(10);

        tag = "R5 miss";
        rel(99); rel(11);

        tag = "R3 full";
        for (int k = 0; k < 8; k++) ins(20 + k, k, k[0]);
        ins(77, 3, 1'b1);                     // ignored
        rel(77);                              // proves it was not stored
        rel(12); rel(20); rel(21);

        tag = "R6 duplicate";
        ins(40, 1, 1'b0); ins(40, 6, 1'b1);
        rel(40); idle();

        tag = "R7 squash";
        cyc(0, 0, 0, 0, 0, 0, 1, 25);
        rel(24); rel(25); rel(26);

        tag = "R8 squash beats release";
        ins(30, 4, 1'b1);
        cyc(0, 0, 0, 0, 1, 30, 1, 28);
        rel(30);

        tag = "R9 same-cycle insert";
        cyc(1, 50, 2, 1'b0, 0, 0, 1, 45);
        rel(50);
        cyc(1, 60, 3, 1'b1, 1, 60, 0, 0);
        rel(60);

        tag = "R4 mixed traffic";
        for (int n = 0; n < 400; n++) begin
            int r;
            r = int'($urandom_range(99, 0));
            cyc(r < 50, int'($urandom_range(15, 0)), int'($urandom_range(7, 0)), r[0],
                r > 45, int'($urandom_range(15, 0)),
                r > 94, int'($urandom_range(15, 6)));
        end
        idle();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule